// File: doc/BRIEF.md
# Flash Program/Erase Status Word Generator

This block produces the status word and the ready/busy indication that a NOR flash bank reports while its embedded program or erase algorithm runs. It follows the bank through idle, byte programming, sector erase (with a window in which further sectors may still be queued), chip erase, erase suspend and programming while suspended. It also models a program aimed at a protected sector, which looks busy for a short interval and then falls back to array reads.

A command decoder in front of the block issues one-cycle command strobes. A host read strobe with an address returns an 8-bit word one clock later. That word is built from the bank state, the sector being read, the last byte handed to the program algorithm and two per-bit toggle flip-flops. An algorithm model raises a completion pulse or a time-limit fault pulse. When no operation is reporting status, reads return array data: the last programmed byte at its own address, 0xFF in freshly erased sectors, or the `array_data` input elsewhere.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `busy_n` is 1, `status` is 0x00 and the bank is idle.
- R2: Command code 1 (program) from idle makes `busy_n` 0. While it runs, status bit 7 reads the inverse of bit 7 of the byte being programmed, and bits 4..0 read 0. After `done`, a read at the program address returns the programmed byte and `busy_n` is 1.
- R3: During an erase (code 2 sector erase, code 3 chip erase) `busy_n` is 0 and status bit 7 reads 0. After `done`, reads in marked sectors return 0xFF and reads in other sectors return `array_data`.
- R4: Status bit 6 is 0 on the first status read after an operation starts and inverts on every later read while a program or erase is active.
- R5: A `time_fault` pulse while busy makes status bit 5 read 1 from then on. Bit 5 reads 0 otherwise and is cleared when the next operation starts.
- R6: After a sector erase command, status bit 3 reads 0 for ERASE_WIN_US microseconds (CLK_MHZ cycles per microsecond). A further sector erase command inside that window marks its sector and restarts the window, and bit 3 reads 1 once the window has run out. Bit 3 always reads 0 during chip erase.
- R7: Status bit 2 inverts on each read of a marked sector while erasing or suspended. It shows its value without changing on reads of an unmarked sector. The sector is the top log2(NUM_SECTORS) address bits.
- R8: Code 4 (suspend) is taken only during active sector erase. It is ignored in the window and during chip erase. Once suspended, `busy_n` is 1, reads of marked sectors give bit 7 = 1, a frozen bit 6, bit 5 = 0, bit 3 = 0 and the toggling bit 2, and reads of unmarked sectors give array data.
- R9: While suspended, a program to an unmarked sector runs with `busy_n` 0 and program status. On `done` it returns to suspend, and the byte reads back at its address. A program to a marked sector is ignored.
- R10: Code 5 (resume) while suspended returns to active erase: `busy_n` 0, bit 7 = 0, bit 3 = 1.
- R11: A program with `cmd_prot` set shows program status with `busy_n` 0 for PROT_US microseconds. It then returns to array reads without storing the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command code: 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume |
| cmd_addr | input | ADDR_W | Command address (program target or sector to erase) |
| cmd_data | input | 8 | Byte to program |
| cmd_prot | input | 1 | Program target lies in a protected sector |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| array_data | input | 8 | Array contents at `rd_addr` |
| done | input | 1 | Algorithm completion pulse |
| time_fault | input | 1 | Algorithm exceeded its time limit |
| status | output | 8 | Word returned by the last read |
| busy_n | output | 1 | Low while an algorithm runs |

## Verification
The bench builds the block with ADDR_W = 8, NUM_SECTORS = 4 and CLK_MHZ = 2. With these values the sector-erase window lasts 100 cycles and the protected-sector interval lasts 2 cycles. Window restart, window expiry and the return from a protected program can therefore be reached with short waits on either side of each limit. Four sectors allow marked and unmarked sectors to be mixed in one erase. Reads across them show bit 2 holding on unmarked sectors and bit 6 freezing in suspend.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_PROG    = 3'd1,
      OP_SERASE  = 3'd2,
      OP_CERASE  = 3'd3,
      OP_SUSPEND = 3'd4,
      OP_RESUME  = 3'd5
   } fsg_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_PROT,
      ST_EWIN,
      ST_EACT,
      ST_CERASE,
      ST_SUSP,
      ST_SPROG
   } fsg_state_e;

   function automatic logic st_busy(fsg_state_e s);
      return (s != ST_IDLE) && (s != ST_SUSP);
   endfunction

   function automatic logic st_erasing(fsg_state_e s);
      return (s == ST_EWIN) || (s == ST_EACT) || (s == ST_CERASE);
   endfunction

endpackage

// File: rtl/fsg_interval_timer.sv
module fsg_interval_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
   end

   assign expire = !load && (cnt_q == W'(1));
endmodule

// File: rtl/fsg_sector_marks.sv
module fsg_sector_marks #(
   parameter int NUM_SECTORS = 8,
   parameter int SECT_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              set_one,
   input  logic              set_all,
   input  logic [SECT_W-1:0] cmd_idx,
   input  logic [SECT_W-1:0] rd_idx,
   output logic              cmd_hit,
   output logic              rd_hit
);
   logic [NUM_SECTORS-1:0] mark_q;

   for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_mark
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mark_q[s] <= 1'b0;
         else if (set_all || (set_one && cmd_idx == SECT_W'(s)))
            mark_q[s] <= 1'b1;
         else if (clr)
            mark_q[s] <= 1'b0;
      end
   end

   assign cmd_hit = mark_q[cmd_idx];
   assign rd_hit  = mark_q[rd_idx];
endmodule

// File: rtl/fsg_toggle_bit.sv
module fsg_toggle_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic flip,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (clr)  q <= 1'b0;
      else if (flip) q <= ~q;
   end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import flash_status_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int NUM_SECTORS   = 8,
   parameter int CLK_MHZ       = 100,
   parameter int ERASE_WIN_US  = 50,
   parameter int PROT_US       = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   input  logic              cmd_prot,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        array_data,
   input  logic              done,
   input  logic              time_fault,
   output logic [7:0]        status,
   output logic              busy_n
);
   localparam int SECT_W   = $clog2(NUM_SECTORS);
   localparam int WIN_CYC  = CLK_MHZ * ERASE_WIN_US;
   localparam int PROT_CYC = CLK_MHZ * PROT_US;
   localparam int TMR_MAX  = (WIN_CYC > PROT_CYC) ? WIN_CYC : PROT_CYC;
   localparam int TMR_W    = $clog2(TMR_MAX + 1);
   localparam int NUM_TOG  = 2;

   if (NUM_SECTORS < 2 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_sectors
      $error("NUM_SECTORS must be a power of two of at least 2");
   end
   if (ADDR_W <= SECT_W) begin : g_bad_addr
      $error("ADDR_W must exceed the sector index width");
   end
   if (CLK_MHZ < 1 || ERASE_WIN_US < 1 || PROT_US < 1) begin : g_bad_time
      $error("timing parameters must be positive");
   end

   fsg_state_e        state_q, state_d;
   logic              ret_susp_q;
   logic [ADDR_W-1:0] pend_addr_q, prog_addr_q;
   logic [7:0]        pend_data_q, prog_data_q;
   logic              prog_valid_q, fault_q;
   logic [7:0]        status_q, status_d, data_word;

   logic [SECT_W-1:0] cmd_sect, rd_sect;
   logic              cmd_hit, rd_hit;
   logic              tmr_load, tmr_expire;
   logic [TMR_W-1:0]  tmr_val;
   logic              op_start, sprog_start, pend_we, commit;
   logic              mark_one, mark_all;
   logic              is_prog, is_serase, is_cerase, is_susp, is_resume;
   logic              busy;
   logic [NUM_TOG-1:0] tog_clr, tog_flip, tog_q;

   assign cmd_sect  = cmd_addr[ADDR_W-1 -: SECT_W];
   assign rd_sect   = rd_addr[ADDR_W-1 -: SECT_W];
   assign is_prog   = cmd_valid && (cmd_op == OP_PROG);
   assign is_serase = cmd_valid && (cmd_op == OP_SERASE);
   assign is_cerase = cmd_valid && (cmd_op == OP_CERASE);
   assign is_susp   = cmd_valid && (cmd_op == OP_SUSPEND);
   assign is_resume = cmd_valid && (cmd_op == OP_RESUME);

   // next-state and control decode
   always_comb begin
      state_d     = state_q;
      op_start    = 1'b0;
      sprog_start = 1'b0;
      pend_we     = 1'b0;
      commit      = 1'b0;
      mark_one    = 1'b0;
      mark_all    = 1'b0;
      tmr_load    = 1'b0;
      tmr_val     = TMR_W'(WIN_CYC);
      case (state_q)
         ST_IDLE: begin
            if (is_prog) begin
               op_start = 1'b1;
               pend_we  = 1'b1;
               if (cmd_prot) begin
                  state_d  = ST_PROT;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(PROT_CYC);
               end else begin
                  state_d = ST_PROG;
               end
            end else if (is_serase) begin
               op_start = 1'b1;
               mark_one = 1'b1;
               tmr_load = 1'b1;
               state_d  = ST_EWIN;
            end else if (is_cerase) begin
               op_start = 1'b1;
               mark_all = 1'b1;
               state_d  = ST_CERASE;
            end
         end
         ST_PROG: if (done) begin
            commit  = 1'b1;
            state_d = ST_IDLE;
         end
         ST_PROT: if (tmr_expire) state_d = ret_susp_q ? ST_SUSP : ST_IDLE;
         ST_EWIN: begin
            if (is_serase) begin
               mark_one = 1'b1;
               tmr_load = 1'b1;
            end else if (tmr_expire) begin
               state_d = ST_EACT;
            end
         end
         ST_EACT: begin
            if (done)         state_d = ST_IDLE;
            else if (is_susp) state_d = ST_SUSP;
         end
         ST_CERASE: if (done) state_d = ST_IDLE;
         ST_SUSP: begin
            if (is_resume) begin
               state_d = ST_EACT;
            end else if (is_prog && !cmd_hit) begin
               sprog_start = 1'b1;
               pend_we     = 1'b1;
               if (cmd_prot) begin
                  state_d  = ST_PROT;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(PROT_CYC);
               end else begin
                  state_d = ST_SPROG;
               end
            end
         end
         ST_SPROG: if (done) begin
            commit  = 1'b1;
            state_d = ST_SUSP;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   fsg_interval_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   fsg_sector_marks #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_marks (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (op_start),
      .set_one (mark_one),
      .set_all (mark_all),
      .cmd_idx (cmd_sect),
      .rd_idx  (rd_sect),
      .cmd_hit (cmd_hit),
      .rd_hit  (rd_hit)
   );

   assign busy = st_busy(state_q);

   // bit 0 of the toggle vector drives status bit 6, bit 1 drives status bit 2
   assign tog_clr[0]  = op_start || sprog_start;
   assign tog_flip[0] = rd_en && busy;
   assign tog_clr[1]  = op_start;
   assign tog_flip[1] = rd_en && rd_hit && (st_erasing(state_q) || state_q == ST_SUSP);

   for (genvar g = 0; g < NUM_TOG; g++) begin : g_tog
      fsg_toggle_bit u_tog (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (tog_clr[g]),
         .flip  (tog_flip[g]),
         .q     (tog_q[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         ret_susp_q   <= 1'b0;
         pend_addr_q  <= '0;
         pend_data_q  <= '0;
         prog_addr_q  <= '0;
         prog_data_q  <= '0;
         prog_valid_q <= 1'b0;
         fault_q      <= 1'b0;
         status_q     <= '0;
      end else begin
         state_q <= state_d;
         if (state_d == ST_PROT && state_q != ST_PROT)
            ret_susp_q <= (state_q == ST_SUSP);
         if (pend_we) begin
            pend_addr_q <= cmd_addr;
            pend_data_q <= cmd_data;
         end
         if (commit) begin
            prog_addr_q  <= pend_addr_q;
            prog_data_q  <= pend_data_q;
            prog_valid_q <= 1'b1;
         end else if (op_start) begin
            prog_valid_q <= 1'b0;
         end
         if (op_start || sprog_start) fault_q <= 1'b0;
         else if (time_fault && busy) fault_q <= 1'b1;
         if (rd_en) status_q <= status_d;
      end
   end

   // word returned on a read
   always_comb begin
      if (prog_valid_q && rd_addr == prog_addr_q) data_word = prog_data_q;
      else if (state_q == ST_IDLE && rd_hit)      data_word = 8'hFF;
      else                                        data_word = array_data;
      case (state_q)
         ST_PROG, ST_PROT, ST_SPROG:
            status_d = {~pend_data_q[7], tog_q[0], fault_q, 5'b00000};
         ST_EWIN, ST_EACT, ST_CERASE:
            status_d = {1'b0, tog_q[0], fault_q, 1'b0, (state_q == ST_EACT), tog_q[1], 2'b00};
         ST_SUSP:
            status_d = rd_hit ? {1'b1, tog_q[0], 3'b000, tog_q[1], 2'b00} : data_word;
         default:
            status_d = data_word;
      endcase
   end

   assign status = status_q;
   assign busy_n = ~busy;
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk
   import flash_status_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic       rd_en,
   input logic       done,
   input logic [7:0] status,
   input logic       busy_n,
   input fsg_state_e state,
   input logic       pend_bit7,
   input logic       cmd_hit
);
   // R2
   prog_poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state == ST_PROG) |=> (status[7] == !$past(pend_bit7)));

   // R4
   busy_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state == ST_PROG && $past(rd_en && state == ST_PROG))
      |=> (status[6] != $past(status[6])));

   // R3
   erase_poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (state == ST_EWIN || state == ST_EACT || state == ST_CERASE))
      |=> !status[7]);

   // R6
   window_bit3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (state == ST_EWIN || state == ST_CERASE)) |=> !status[3]);

   // R8
   suspend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_SUSPEND && state == ST_EACT && !done) |=> busy_n);

   // R9
   marked_prog_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUSP && cmd_valid && cmd_op == OP_PROG && cmd_hit)
      |=> (state == ST_SUSP && busy_n));

   // R10
   resume_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUSP && cmd_valid && cmd_op == OP_RESUME)
      |=> (!busy_n && state == ST_EACT));
endmodule

bind flash_status_gen flash_status_gen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .rd_en     (rd_en),
   .done      (done),
   .status    (status),
   .busy_n    (busy_n),
   .state     (state_q),
   .pend_bit7 (pend_data_q[7]),
   .cmd_hit   (cmd_hit)
);

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
   localparam int ADDR_W = 8;
   localparam int NSECT  = 4;
   localparam int MHZ    = 2;
   localparam int WIN    = MHZ * 50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_addr = 8'h00;
   logic [7:0] cmd_data = 8'h00;
   logic       cmd_prot = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_addr = 8'h00;
   logic [7:0] array_data = 8'h3C;
   logic       done = 1'b0;
   logic       time_fault = 1'b0;
   logic [7:0] status;
   logic       busy_n;

   int n_chk = 0;
   int n_err = 0;
   bit m_t6 = 1'b0;
   bit m_t2 = 1'b0;

   flash_status_gen #(
      .ADDR_W(ADDR_W), .NUM_SECTORS(NSECT), .CLK_MHZ(MHZ)
   ) u_flash_status_gen (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_prot(cmd_prot),
      .rd_en(rd_en), .rd_addr(rd_addr), .array_data(array_data),
      .done(done), .time_fault(time_fault), .status(status), .busy_n(busy_n)
   );

   always #5 clk = ~clk;

   task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic chk1(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic send(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d, input bit prot);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_prot = prot;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_prot = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse_done();
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   task automatic pulse_fault();
      time_fault = 1'b1;
      @(negedge clk);
      time_fault = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_prog(input logic [7:0] a, input bit d7, input bit f, input string tag);
      logic [7:0] exp = {~d7, m_t6, f, 5'b00000};
      rd(a);
      chk8(status, exp, tag);
      m_t6 = ~m_t6;
   endtask

   task automatic rd_erase(input logic [7:0] a, input bit marked, input bit act, input string tag);
      logic [7:0] exp = {1'b0, m_t6, 1'b0, 1'b0, act, m_t2, 2'b00};
      rd(a);
      chk8(status, exp, tag);
      m_t6 = ~m_t6;
      if (marked) m_t2 = ~m_t2;
   endtask

   task automatic rd_susp(input logic [7:0] a, input string tag);
      logic [7:0] exp = {1'b1, m_t6, 3'b000, m_t2, 2'b00};
      rd(a);
      chk8(status, exp, tag);
      m_t2 = ~m_t2;
   endtask

   task automatic rd_data(input logic [7:0] a, input logic [7:0] exp, input string tag);
      rd(a);
      chk8(status, exp, tag);
   endtask

   task automatic t_reset();
      chk1(busy_n, 1'b1, "R1 busy_n after reset");
      chk8(status, 8'h00, "R1 status after reset");
   endtask

   task automatic t_program();
      send(3'd1, 8'h12, 8'hA5, 1'b0);
      m_t6 = 1'b0; m_t2 = 1'b0;
      chk1(busy_n, 1'b0, "R2 busy during program");
      rd_prog(8'h12, 1'b1, 1'b0, "R2 R4 first read");
      rd_prog(8'h12, 1'b1, 1'b0, "R4 second read");
      rd_prog(8'h12, 1'b1, 1'b0, "R4 third read");
      pulse_done();
      chk1(busy_n, 1'b1, "R2 ready after done");
      rd_data(8'h12, 8'hA5, "R2 programmed byte");
      rd_data(8'h13, 8'h3C, "R2 other address");
   endtask

   task automatic t_fault();
      send(3'd1, 8'h20, 8'h11, 1'b0);
      m_t6 = 1'b0;
      rd_prog(8'h20, 1'b0, 1'b0, "R5 before fault");
      pulse_fault();
      rd_prog(8'h20, 1'b0, 1'b1, "R5 fault seen");
      pulse_done();
      send(3'd1, 8'h21, 8'h90, 1'b0);
      m_t6 = 1'b0;
      rd_prog(8'h21, 1'b1, 1'b0, "R5 cleared at new op");
      pulse_done();
   endtask

   task automatic t_sector_erase();
      send(3'd2, 8'h40, 8'h00, 1'b0);
      m_t6 = 1'b0; m_t2 = 1'b0;
      chk1(busy_n, 1'b0, "R3 busy during erase");
      rd_erase(8'h40, 1'b1, 1'b0, "R6 R7 window read 1");
      rd_erase(8'h40, 1'b1, 1'b0, "R7 window read 2");
      idle(WIN / 2);
      send(3'd2, 8'hC0, 8'h00, 1'b0);
      idle(WIN / 2 + 10);
      rd_erase(8'hC0, 1'b1, 1'b0, "R6 window restarted");
      rd_erase(8'h80, 1'b0, 1'b0, "R7 unmarked read");
      rd_erase(8'hC0, 1'b1, 1'b0, "R7 bit2 held by unmarked read");
      idle(WIN / 2);
      rd_erase(8'h40, 1'b1, 1'b1, "R6 window expired");
   endtask

   task automatic t_suspend();
      send(3'd4, 8'h00, 8'h00, 1'b0);
      chk1(busy_n, 1'b1, "R8 ready in suspend");
      rd_susp(8'h40, "R8 suspended sector read 1");
      rd_susp(8'h40, "R8 suspended sector read 2");
      rd_data(8'h80, 8'h3C, "R8 unmarked sector data");
      send(3'd1, 8'h41, 8'h00, 1'b0);
      chk1(busy_n, 1'b1, "R9 marked program ignored");
      rd_susp(8'h41, "R9 still suspended");
      send(3'd1, 8'h85, 8'h7E, 1'b0);
      m_t6 = 1'b0;
      chk1(busy_n, 1'b0, "R9 busy programming in suspend");
      rd_prog(8'h85, 1'b0, 1'b0, "R9 program status in suspend");
      pulse_done();
      chk1(busy_n, 1'b1, "R9 back to suspend");
      rd_data(8'h85, 8'h7E, "R9 byte read back");
      send(3'd5, 8'h00, 8'h00, 1'b0);
      chk1(busy_n, 1'b0, "R10 busy after resume");
      rd_erase(8'h40, 1'b1, 1'b1, "R10 active erase status");
      pulse_done();
      chk1(busy_n, 1'b1, "R3 ready after erase");
      rd_data(8'h40, 8'hFF, "R3 erased sector 1");
      rd_data(8'hC0, 8'hFF, "R3 erased sector 3");
      rd_data(8'h80, 8'h3C, "R3 unmarked sector");
   endtask

   task automatic t_window_suspend();
      send(3'd2, 8'h00, 8'h00, 1'b0);
      m_t6 = 1'b0; m_t2 = 1'b0;
      send(3'd4, 8'h00, 8'h00, 1'b0);
      chk1(busy_n, 1'b0, "R8 suspend ignored in window");
      rd_erase(8'h00, 1'b1, 1'b0, "R8 still in window");
      idle(WIN + 5);
      pulse_done();
      chk1(busy_n, 1'b1, "R3 ready after second erase");
   endtask

   task automatic t_chip_erase();
      send(3'd3, 8'h00, 8'h00, 1'b0);
      m_t6 = 1'b0; m_t2 = 1'b0;
      send(3'd4, 8'h00, 8'h00, 1'b0);
      chk1(busy_n, 1'b0, "R8 suspend ignored in chip erase");
      rd_erase(8'h80, 1'b1, 1'b0, "R6 chip erase bit3 low");
      rd_erase(8'h13, 1'b1, 1'b0, "R6 R7 chip erase read 2");
      pulse_done();
      rd_data(8'h13, 8'hFF, "R3 chip erased");
   endtask

   task automatic t_protected();
      send(3'd1, 8'h50, 8'h80, 1'b1);
      m_t6 = 1'b0;
      chk1(busy_n, 1'b0, "R11 busy on protected program");
      rd_prog(8'h50, 1'b1, 1'b0, "R11 polling on protected program");
      idle(3);
      chk1(busy_n, 1'b1, "R11 ready after interval");
      rd_data(8'h50, 8'h3C, "R11 byte not stored");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_program();
      t_fault();
      t_sector_erase();
      t_suspend();
      t_window_suspend();
      t_chip_erase();
      t_protected();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule